// File: doc/BRIEF.md
# Serial Flash Command Shift Engine

This block runs one serial flash command at a time from three software-visible registers. Software first loads a 32-bit command word and a 32-bit data word. It then writes the control word, which holds a transmit byte count, a receive byte count and a launch bit. The engine lowers chip select and shifts the transmit stream out on MOSI. The stream is the command byte, then the address bytes, then the data-word bytes. After that the engine clocks in the requested number of reply bytes from MISO. A busy flag covers the whole transfer.

The serial clock is a fixed division of the system clock, set by the `HALF_DIV` parameter, which is the number of system cycles per serial clock half period. The engine uses SPI mode 0. Every byte is shifted most significant bit first. Reply bytes are stored right-aligned in the data word, and the bytes above the receive count read as zero. A status poll is one byte out and one byte back. A signature probe is four bytes out and one byte back.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, and all three registers read as zero: control (rd_sel 0), command (rd_sel 1) and data (rd_sel 2).
- R2: A write of wr_sel 0 with wr_data[8] set while idle launches a command. Busy (control read bit 16) is 1 from the next cycle until cs_n rises. cs_n stays low for exactly HALF_DIV*(3+16*(tx+rx)) cycles.
- R3: Control bits [3:0] give the transmit count and bits [7:4] give the receive count. A transmit count above 8 is treated as 8, and a receive count above 4 is treated as 4. The control read returns the effective counts of the last launched command in bits [3:0] and [7:4]. The number of sck rising edges equals 8*(tx+rx).
- R4: Transmit byte k is selected as follows. k=0 is command bits [7:0]. k=1, 2 and 3 are command bits [31:24], [23:16] and [15:8], so the address goes most significant byte first. k=4 to 7 are data bytes 0 to 3, taken from bits [7:0] upward. Each byte is sent MSB first. MOSI is 0 during the receive bytes.
- R5: Receive byte j, the j-th byte after the transmit bytes, is stored in data bits [8j+7:8j]. When the receive count is non-zero, the data bytes at and above the receive count read as zero. When the receive count is zero, the data register keeps its value.
- R6: The clock follows mode 0. sck is low whenever cs_n is high. MOSI changes only while sck is low. MISO is sampled on the rising edge. The first rising edge comes 2*HALF_DIV cycles after cs_n falls, and cs_n rises 2*HALF_DIV cycles after the last falling edge.
- R7: A launch written while busy is ignored. It changes neither the running transfer, nor its length, nor the reported counts.
- R8: Writes to the command or data register while busy are ignored.
- R9: A status poll (1 out, 1 in) and a signature probe (4 out, 1 in) each return the reply byte in data bits [7:0], with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 command, 2 data |
| wr_data | input | 32 | Write value |
| rd_sel | input | 2 | Read target: 0 control, 1 command, 2 data |
| rd_data | output | 32 | Read value (combinational) |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A wrong bit counter or a wrong byte select shows within the same transfer. It changes the number of sck edges, the cs_n low time, or a byte on MOSI, and each of these is checked at the end of every command. A wrong receive-byte index or a missing clear corrupts the data register, and the next read of that register reveals it. Every transmit/receive count pair of the small configuration is swept, together with launches and register writes made during a transfer. A stale state therefore shows up within one command.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int MAX_TX = 8;
  localparam int MAX_RX = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} sfe_state_e;

  // limit a requested byte count to what the engine supports
  function automatic logic [3:0] clamp_cnt(input logic [3:0] v, input logic [3:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  // byte k of the outgoing stream: command, address high..low, data low..high
  function automatic logic [7:0] tx_byte(input logic [3:0] k, input logic [31:0] op,
                                         input logic [31:0] d);
    logic [7:0] r;
    if (k == 4'd0)      r = op[7:0];
    else if (k < 4'd4)  r = 8'(op >> (8 * (4 - int'(k))));
    else if (k < 4'd8)  r = 8'(d >> (8 * (int'(k) - 4)));
    else                r = 8'h00;
    return r;
  endfunction
endpackage

// File: rtl/sfe_tick_gen.sv
module sfe_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [W-1:0] LAST = W'(HALF_DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter
  import sfe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  tx_cnt,
  input  logic [3:0]  rx_cnt,
  input  logic [31:0] op,
  input  logic [31:0] dat,
  input  logic        tick,
  input  logic        miso,
  output logic        run,
  output logic        cs_n,
  output logic        sck,
  output logic        mosi,
  output logic        rx_valid,
  output logic [3:0]  rx_idx,
  output logic [7:0]  rx_byte,
  output logic        done
);
  sfe_state_e  state;
  logic        phase;
  logic [6:0]  bit_idx;
  logic [3:0]  tx_q, rx_q;
  logic [31:0] op_q, dat_q;
  logic [6:0]  rx_sh;

  logic [3:0]  nbytes;
  logic [6:0]  total_bits;
  logic [3:0]  byte_k;
  logic [2:0]  bit_in;
  logic        in_tx;
  logic [7:0]  cur_byte;
  logic        sample;

  assign nbytes     = tx_q + rx_q;
  assign total_bits = {nbytes, 3'b000};
  assign byte_k     = bit_idx[6:3];
  assign bit_in     = bit_idx[2:0];
  assign in_tx      = byte_k < tx_q;
  assign cur_byte   = tx_byte(byte_k, op_q, dat_q);

  assign run      = (state != ST_IDLE);
  assign cs_n     = (state == ST_IDLE);
  assign sck      = (state == ST_SHIFT) && phase;
  assign mosi     = (state == ST_SHIFT) && in_tx && cur_byte[3'd7 - bit_in];
  assign sample   = (state == ST_SHIFT) && tick && !phase;
  assign rx_valid = sample && !in_tx && (bit_in == 3'd7);
  assign rx_idx   = byte_k - tx_q;
  assign rx_byte  = {rx_sh, miso};
  assign done     = (state == ST_TRAIL) && tick && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= 1'b0;
      bit_idx <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      op_q    <= '0;
      dat_q   <= '0;
      rx_sh   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          tx_q    <= tx_cnt;
          rx_q    <= rx_cnt;
          op_q    <= op;
          dat_q   <= dat;
          bit_idx <= '0;
          phase   <= 1'b0;
          state   <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          phase <= 1'b0;
          state <= (total_bits == 7'd0) ? ST_TRAIL : ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (!phase) begin
            phase <= 1'b1;
            rx_sh <= {rx_sh[5:0], miso};
          end else begin
            phase <= 1'b0;
            if (bit_idx == total_bits - 7'd1) state <= ST_TRAIL;
            else                              bit_idx <= bit_idx + 7'd1;
          end
        end
        ST_TRAIL: if (tick) begin
          if (phase) begin
            phase <= 1'b0;
            state <= ST_IDLE;
          end else begin
            phase <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
  import sfe_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        cs_n,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  localparam logic [3:0] TX_LIM = 4'(MAX_TX);
  localparam logic [3:0] RX_LIM = 4'(MAX_RX);

  logic [31:0] op_r, dat_r;
  logic [3:0]  tx_r, rx_r;
  logic        busy, tick, done;
  logic        rx_valid;
  logic [3:0]  rx_idx;
  logic [7:0]  rx_byte;

  // named events for the checker
  logic       start_req, start_fire, start_ignored;
  logic       op_we, dat_we;
  logic [3:0] tx_in, rx_in;

  assign start_req     = wr_en && (wr_sel == 2'd0) && wr_data[8];
  assign start_fire    = start_req && !busy;
  assign start_ignored = start_req && busy;
  assign op_we         = wr_en && (wr_sel == 2'd1) && !busy;
  assign dat_we        = wr_en && (wr_sel == 2'd2) && !busy;
  assign tx_in         = clamp_cnt(wr_data[3:0], TX_LIM);
  assign rx_in         = clamp_cnt(wr_data[7:4], RX_LIM);

  sfe_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  sfe_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_fire),
    .tx_cnt  (tx_in),
    .rx_cnt  (rx_in),
    .op      (op_r),
    .dat     (dat_r),
    .tick    (tick),
    .miso    (miso),
    .run     (busy),
    .cs_n    (cs_n),
    .sck     (sck),
    .mosi    (mosi),
    .rx_valid(rx_valid),
    .rx_idx  (rx_idx),
    .rx_byte (rx_byte),
    .done    (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_r  <= '0;
      dat_r <= '0;
      tx_r  <= '0;
      rx_r  <= '0;
    end else begin
      if (op_we)  op_r  <= wr_data;
      if (dat_we) dat_r <= wr_data;
      if (start_fire) begin
        tx_r <= tx_in;
        rx_r <= rx_in;
        if (rx_in != 4'd0) dat_r <= '0;
      end
      for (int j = 0; j < MAX_RX; j++) begin
        if (rx_valid && (rx_idx == 4'(j))) dat_r[8*j +: 8] <= rx_byte;
      end
    end
  end

  always_comb begin
    unique case (rd_sel)
      2'd0:    rd_data = {15'd0, busy, 8'd0, rx_r, tx_r};
      2'd1:    rd_data = op_r;
      2'd2:    rd_data = dat_r;
      default: rd_data = 32'd0;
    endcase
  end
endmodule

// File: rtl/sfe_chk.sv
module sfe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sck,
  input logic        mosi,
  input logic        busy,
  input logic        start_fire,
  input logic        start_ignored,
  input logic        rx_valid,
  input logic        done,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [3:0]  tx_r,
  input logic [3:0]  rx_r,
  input logic [31:0] op_r
);
  // R6
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (busy && !cs_n));
  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cs_n && !busy));
  // R7
  ignored_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ignored |=> ($stable(tx_r) && $stable(rx_r) && busy));
  // R8
  busy_op_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && (wr_sel == 2'd1)) |=> $stable(op_r));
  // R5
  rx_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (busy && !cs_n && !sck));
endmodule

bind sflash_cmd_engine sfe_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .sck          (sck),
  .mosi         (mosi),
  .busy         (busy),
  .start_fire   (start_fire),
  .start_ignored(start_ignored),
  .rx_valid     (rx_valid),
  .done         (done),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .tx_r         (tx_r),
  .rx_r         (rx_r),
  .op_r         (op_r)
);

// File: tb/sflash_cmd_engine_tb.sv
`timescale 1ns/1ps
module sflash_cmd_engine_tb;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        cs_n, sck, mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;

  sflash_cmd_engine #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  always #2 clk = ~clk;

  // flash model state
  int         seed = 0;
  int         cyc = 0;
  logic       pcs = 1'b1, psck = 1'b0;
  int         t_csf = 0, t_rise1 = 0, t_lastf = 0, t_csr = 0, lowcnt = 0, nrise = 0;
  logic [7:0] got [12];

  function automatic logic [7:0] reply(input int m, input int s);
    return 8'((m * 29 + s) ^ 8'h5A);
  endfunction

  function automatic logic reply_bit(input int n, input int s);
    logic [7:0] b;
    b = reply(n / 8, s);
    return b[7 - (n % 8)];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (pcs && !cs_n) begin
      t_csf = cyc; nrise = 0; lowcnt = 0;
      miso = reply_bit(0, seed);
    end
    if (!cs_n) lowcnt++;
    if (!psck && sck) begin
      if (nrise == 0) t_rise1 = cyc;
      if (nrise < 96) got[nrise / 8][7 - (nrise % 8)] = mosi;
      nrise++;
    end
    if (psck && !sck) begin
      t_lastf = cyc;
      miso = reply_bit(nrise, seed);
    end
    if (!pcs && cs_n) t_csr = cyc;
    pcs = cs_n;
    psck = sck;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    rd_sel = s;
    #1 v = rd_data;
    rd_sel = 2'd0;
  endtask

  task automatic run_cmd(input logic [31:0] op, input logic [31:0] dat,
                         input int txf, input int rxf, input int sd, input bit poke);
    int tx, rx, nb, guard;
    logic [63:0]  src;
    logic [95:0]  e_str, a_str;
    logic [31:0]  e_dat, v;
    tx = (txf > 8) ? 8 : txf;
    rx = (rxf > 4) ? 4 : rxf;
    nb = tx + rx;
    wr(2'd1, op);
    wr(2'd2, dat);
    seed = sd;
    for (int k = 0; k < 12; k++) got[k] = 8'h00;
    wr(2'd0, {23'd0, 1'b1, 4'(rxf), 4'(txf)});
    // R2: busy visible right after launch
    chk(rd_data[16] == 1'b1, "R2 busy after launch", 128'(rd_data[16]), 128'd1);
    if (poke) begin
      // R7: second launch with other counts; R8: register writes while busy
      wr(2'd0, {23'd0, 1'b1, 4'd4, 4'd8});
      wr(2'd1, ~op);
      wr(2'd2, ~dat);
    end
    guard = 0;
    while (cs_n === 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    chk(guard < 5000, "R2 transfer ends", 128'(guard), 128'd0);
    chk(lowcnt == HALF * (3 + 16 * nb), "R2 R7 cs_n low cycles", 128'(lowcnt),
        128'(HALF * (3 + 16 * nb)));
    chk(nrise == 8 * nb, "R3 sck rising edges", 128'(nrise), 128'(8 * nb));
    // R4 expected stream
    src = {op[7:0], op[31:24], op[23:16], op[15:8], dat[7:0], dat[15:8], dat[23:16], dat[31:24]};
    e_str = '0; a_str = '0;
    for (int k = 0; k < 12; k++) begin
      if (k < nb) begin
        a_str[8*(11-k) +: 8] = got[k];
        if (k < tx) e_str[8*(11-k) +: 8] = src[8*(7-k) +: 8];
      end
    end
    chk(a_str == e_str, "R4 mosi stream", 128'(a_str), 128'(e_str));
    if (nb > 0) begin
      chk(t_rise1 - t_csf == 2 * HALF, "R6 lead time", 128'(t_rise1 - t_csf), 128'(2 * HALF));
      chk(t_csr - t_lastf == 2 * HALF, "R6 trail time", 128'(t_csr - t_lastf), 128'(2 * HALF));
    end
    e_dat = dat;
    if (rx > 0) begin
      e_dat = '0;
      for (int j = 0; j < rx; j++) e_dat[8*j +: 8] = reply(tx + j, sd);
    end
    rd(2'd2, v);
    chk(v == e_dat, "R5 R8 data register", 128'(v), 128'(e_dat));
    if ((tx == 1 || tx == 4) && rx == 1)
      chk(v == {24'd0, reply(tx, sd)}, "R9 status or signature reply", 128'(v),
          128'({24'd0, reply(tx, sd)}));
    rd(2'd0, v);
    chk(v == {24'd0, 4'(rx), 4'(tx)}, "R3 R7 control readback", 128'(v),
        128'({24'd0, 4'(rx), 4'(tx)}));
    rd(2'd1, v);
    chk(v == op, "R8 command register kept", 128'(v), 128'(op));
  endtask

  initial begin
    logic [31:0] v;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 idle pins", 128'({cs_n, sck}), 128'(2'b10));
    rst_n = 1'b1;
    rd(2'd0, v); chk(v == 32'd0, "R1 control reset", 128'(v), 128'd0);
    rd(2'd1, v); chk(v == 32'd0, "R1 command reset", 128'(v), 128'd0);
    rd(2'd2, v); chk(v == 32'd0, "R1 data reset", 128'(v), 128'd0);

    for (int t = 0; t <= 8; t++) begin
      for (int r = 0; r <= 4; r++) begin
        run_cmd(32'hA1B2C3D4 ^ (32'(t) * 32'h01010101) ^ (32'(r) << 5),
                32'h11223344 + 32'(t) * 32'h9 + 32'(r) * 32'h100, t, r, t * 5 + r, 1'b0);
      end
    end
    // R3 clamping of oversized counts
    run_cmd(32'h0BADF00D, 32'hCAFE1234, 15, 7, 77, 1'b0);
    run_cmd(32'h13572468, 32'h89ABCDEF, 9, 5, 91, 1'b0);
    // R7 R8 launches and writes while busy
    run_cmd(32'h00FF9F03, 32'h76543210, 6, 0, 12, 1'b1);
    run_cmd(32'h12345605, 32'hFEDCBA98, 2, 1, 33, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule